// File: doc/BRIEF.md
# Cache Way Allocator with Half Lock

This block picks the replacement way for a four-way set-associative cache whenever a line is to be allocated. The caller presents the four valid bits of the addressed set with an allocate strobe. The chosen way index appears combinationally in the same cycle. When some allowed way is empty, the lowest-numbered empty one is taken. When every allowed way is full, a round-robin counter inside the block names the victim, and the counter then moves on.

A half-lock control can be changed at any moment. While it is high, allocation is confined to ways 2 and 3, so whatever ways 0 and 1 hold is preserved. In this mode only the counter's high bit is used and advanced. The counter's value carries across mode changes without reinitialisation.

Top module: `way_alloc`

## Requirements
- R1: With half_lock low and alloc_req high, if any valid bit is 0, alloc_way is the lowest index whose way_valid bit is 0.
- R2: With half_lock low, alloc_req high and way_valid all ones, alloc_way equals the round-robin counter, and the counter then increments modulo 4 at the clock edge.
- R3: With half_lock high and alloc_req high, if way_valid[2] or way_valid[3] is 0, alloc_way is 2 when way_valid[2] is 0, otherwise 3; the valid bits of ways 0 and 1 are ignored.
- R4: With half_lock high, alloc_req high and way_valid[3:2] both 1, alloc_way is 2 when counter bit 1 is 0 and 3 when it is 1; at the clock edge counter bit 1 toggles and bit 0 is kept.
- R5: While half_lock is high, alloc_way is never 0 or 1 on an allocation.
- R6: The counter changes only on a clock edge where alloc_req is high and the victim came from the counter; a cycle in which an empty way is taken, or alloc_req is low, leaves it unchanged.
- R7: half_lock may change between any two allocations, and the counter value carries over unchanged across the switch.
- R8: Synchronous active-high reset sets the counter to 0; alloc_way depends combinationally on the current inputs and the counter, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation strobe; one allocation per high cycle |
| half_lock | input | 1 | Restricts allocation to ways 2 and 3 |
| way_valid | input | 4 | Valid bit of each way in the addressed set, bit i for way i |
| alloc_way | output | 2 | Selected way index |

## Verification
The bench sweeps all sixteen valid patterns in both modes over repeated passes, so the counter is observed at every phase. A priority encoder that scanned from the wrong end, or that let ways 0 and 1 through under lock, would name the wrong way. A counter that advanced on free-way picks or idle cycles would drift out of step with the reference model. A counter that cleared its low bit in lock mode, or restarted on a mode switch, would show up during the tightly alternating mode sequences as a wrong victim in normal mode. Reset is checked by the first all-full allocation returning way 0.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;

    localparam int WAYS  = 4;
    localparam int WAY_W = $clog2(WAYS);
    localparam int HALF  = WAYS / 2;

    typedef logic [WAY_W-1:0] way_idx_t;
    typedef logic [WAYS-1:0]  way_vec_t;

    typedef enum logic {
        SRC_FREE    = 1'b0,
        SRC_COUNTER = 1'b1
    } sel_src_e;

    typedef struct packed {
        sel_src_e src;
        way_idx_t way;
    } sel_t;

    // Ways that may receive a new line in the given mode.
    function automatic way_vec_t allowed_mask(input logic locked);
        way_vec_t m;
        for (int i = 0; i < WAYS; i++) begin
            m[i] = !locked || (i >= HALF);
        end
        return m;
    endfunction

    // Victim named by the counter in the given mode.
    function automatic way_idx_t counter_victim(input logic locked, input way_idx_t cnt);
        way_idx_t v;
        if (locked) begin
            v = way_idx_t'(HALF) + way_idx_t'(cnt >> 1);
        end else begin
            v = cnt;
        end
        return v;
    endfunction

endpackage

// File: rtl/wa_free_finder.sv
module wa_free_finder
    import way_alloc_pkg::*;
(
    input  way_vec_t valid,
    input  way_vec_t allowed,
    output logic     found,
    output way_idx_t idx
);
    way_vec_t empty;

    assign empty = ~valid & allowed;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (empty[i]) begin
                found = 1'b1;
                idx   = way_idx_t'(i);
            end
        end
    end
endmodule

// File: rtl/wa_rr_counter.sv
module wa_rr_counter
    import way_alloc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     advance,
    input  logic     locked,
    output way_idx_t cnt
);
    way_idx_t cnt_q;
    way_idx_t step;

    // Normal mode steps by one; lock mode steps the bits above bit 0.
    assign step = locked ? way_idx_t'(2) : way_idx_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (advance) begin
            if (locked) begin
                cnt_q <= {cnt_q[WAY_W-1:1] + 1'b1, cnt_q[0]};
            end else begin
                cnt_q <= cnt_q + step;
            end
        end
    end

    assign cnt = cnt_q;

    // R6: without an advance request the counter holds
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(cnt_q));

    // R4: in lock mode the low counter bit is preserved
    a_r4_low_kept: assert property (@(posedge clk) disable iff (rst)
        (advance && locked) |=> (cnt_q[0] == $past(cnt_q[0])));

    // R2: normal-mode advance changes the counter
    a_r2_moves: assert property (@(posedge clk) disable iff (rst)
        (advance && !locked) |=> !$stable(cnt_q));
endmodule

// File: rtl/way_alloc.sv
module way_alloc
    import way_alloc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alloc_req,
    input  logic       half_lock,
    input  logic [3:0] way_valid,
    output logic [1:0] alloc_way
);
    way_vec_t allowed;
    logic     free_found;
    way_idx_t free_idx;
    way_idx_t rr_cnt;
    sel_t     sel;
    logic     advance;

    assign allowed = allowed_mask(half_lock);

    wa_free_finder u_find (
        .valid   (way_valid),
        .allowed (allowed),
        .found   (free_found),
        .idx     (free_idx)
    );

    always_comb begin
        if (free_found) begin
            sel.src = SRC_FREE;
            sel.way = free_idx;
        end else begin
            sel.src = SRC_COUNTER;
            sel.way = counter_victim(half_lock, rr_cnt);
        end
    end

    assign advance = alloc_req && (sel.src == SRC_COUNTER);

    wa_rr_counter u_rr (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .locked  (half_lock),
        .cnt     (rr_cnt)
    );

    assign alloc_way = sel.way;

    // R5: locked ways never chosen
    a_r5_no_locked: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && half_lock) |-> (alloc_way >= 2'(HALF)));

    // R1: an empty way 0 wins in normal mode
    a_r1_way0_first: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !half_lock && !way_valid[0]) |-> (alloc_way == 2'd0));

    // R3: a free upper way is always the one taken under lock
    a_r3_free_upper: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && half_lock && !(&way_valid[3:2])) |-> !way_valid[alloc_way]);

    // R2: full set in normal mode takes the counter value
    a_r2_counter_pick: assert property (@(posedge clk) disable iff (rst)
        (alloc_req && !half_lock && (&way_valid)) |-> (alloc_way == rr_cnt));
endmodule

// File: tb/way_alloc_tb.sv
module way_alloc_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       alloc_req;
    logic       half_lock;
    logic [3:0] way_valid;
    logic [1:0] alloc_way;

    int errors = 0;
    int checks = 0;
    logic [1:0] m_cnt;
    bit done = 0;

    always #10 clk = ~clk;

    way_alloc dut_i (
        .clk       (clk),
        .rst       (rst),
        .alloc_req (alloc_req),
        .half_lock (half_lock),
        .way_valid (way_valid),
        .alloc_way (alloc_way)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: alloc_way=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus; check before the edge, update the model at it.
    task automatic step(input logic req, input logic hl, input logic [3:0] v, input string extra);
        int exp;
        string tag;
        bit from_cnt;
        @(negedge clk);
        alloc_req = req;
        half_lock = hl;
        way_valid = v;
        from_cnt = 0;
        if (!hl) begin
            if (v != 4'hF) begin
                exp = 3;
                for (int i = 3; i >= 0; i--) if (!v[i]) exp = i;
                tag = "R1";
            end else begin
                exp = m_cnt;
                tag = "R2";
                from_cnt = 1;
            end
        end else begin
            if (v[3:2] != 2'b11) begin
                exp = v[2] ? 3 : 2;
                tag = "R3";
            end else begin
                exp = 2 + m_cnt[1];
                tag = "R4";
                from_cnt = 1;
            end
        end
        #5;
        if (req) begin
            check({tag, extra}, alloc_way, exp);
            if (hl) begin
                checks++;
                if (alloc_way < 2) begin
                    errors++;
                    $display("FAIL R5: alloc_way=%0d expected>=2", alloc_way);
                end
            end
            if (from_cnt) begin
                if (hl) m_cnt[1] = ~m_cnt[1];
                else    m_cnt = m_cnt + 2'd1;
            end
        end
    endtask

    initial begin
        rst = 1'b1; alloc_req = 1'b0; half_lock = 1'b0; way_valid = 4'h0;
        m_cnt = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R8: first full allocation after reset takes way 0, same cycle
        step(1, 0, 4'hF, " R8 reset");

        // R1, R2, R3, R4, R5: sweeps over both modes, every pattern
        for (int pass = 0; pass < 6; pass++) begin
            for (int hl = 0; hl < 2; hl++) begin
                for (int v = 0; v < 16; v++) begin
                    step(1, hl[0], v[3:0], " sweep");
                end
            end
        end

        // R6: idle cycles and free-way picks must not move the counter
        step(1, 0, 4'hF, " R6 pre");
        for (int k = 0; k < 5; k++) step(0, k[0], 4'hF, "");
        step(1, 0, 4'hF, " R6 after idle");
        step(1, 0, 4'h7, " R6 free");
        step(1, 1, 4'hB, " R6 free");
        step(1, 0, 4'hF, " R6 after free");

        // R7: rapid mode switching with full sets, counter carried over
        for (int k = 0; k < 24; k++) begin
            step(1, (k % 3) != 0, 4'hF, " R7 switch");
        end
        for (int k = 0; k < 16; k++) begin
            step(1, k[1], 4'hF, " R7 pairs");
        end

        // R8: reset mid-run returns the counter to 0
        @(negedge clk); rst = 1'b1; alloc_req = 1'b0;
        @(negedge clk); rst = 1'b0; m_cnt = 2'd0;
        step(1, 1, 4'hF, " R8 reset lock");
        step(1, 0, 4'hF, " R8 reset normal");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=20000 expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule